// File: doc/BRIEF.md
# Transceiver Startup Reset Sequencer

This block puts a serial transceiver through its reset steps after the device has been configured. Right after power-up the transceiver does not react to any of its reset inputs. The sequencer therefore first waits, with every reset low, for about 2.5 µs. It derives that wait from the frequency of its free-running clock and rounds the cycle count up. It then pulses the PLL reset while holding the transmit and receive resets. Once PLL lock is seen, it holds those two resets for a fixed number of further cycles and then releases them. Finally it waits until both directions report that their reset has finished, and only then raises the link-ready output.

With the transceiver's output clock dividers at a ratio of 1, the first boot gives only a few bad clock cycles and then no valid clock at all. Setting the `div1_mode` input makes the sequencer run the whole PLL/TX/RX sequence a second time before it declares the link ready. With dividers of 2 or 4 the input stays low and one pass is enough.

A timeout guards each wait for lock and each wait for reset-done. When a timeout expires, the sequence starts over from the PLL reset. Losing PLL lock while ready drops `link_ready` and also restarts the sequence from the PLL reset. The lock and done inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. All pins are plain level signals and there is no data stream.

Top module: `xrs_reset_seq`

## Requirements
- R1: While `rst_n` is low, `pll_rst`, `tx_rst`, `rx_rst` and `link_ready` are all 0.
- R2: After `rst_n` is released, no reset output is asserted for ceil(CLK_FREQ_HZ × BLIND_NS / 1e9) cycles. That is 83 cycles at 33 MHz and 2500 ns. `pll_rst` first reads 1 in the sample after that many rising edges.
- R3: `pll_rst` is high for exactly PLL_PULSE cycles, and `tx_rst` and `rx_rst` are high during every cycle in which `pll_rst` is high.
- R4: `tx_rst` and `rx_rst` stay high until lock is seen. They fall SYNC_STAGES + TXRX_HOLD cycles after `pll_lock` is first sampled high.
- R5: `link_ready` rises SYNC_STAGES cycles after `tx_done` and `rx_done` are both first sampled high. It never rises while either one is low.
- R6: With `div1_mode` = 0 there is one `pll_rst` pulse before `link_ready`. With `div1_mode` = 1 there are exactly two.
- R7: When `pll_lock` falls while ready, `link_ready` falls and `pll_rst` rises SYNC_STAGES cycles after the low lock is first sampled. The sequence then completes again once lock returns.
- R8: If lock does not arrive, `pll_rst` rises again LOCK_TO cycles after it fell.
- R9: If reset-done does not arrive from both directions, `pll_rst` rises DONE_TO cycles after `tx_rst` fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of frequency CLK_FREQ_HZ |
| rst_n | input | 1 | Active-low reset; its release marks power-up |
| div1_mode | input | 1 | 1 = run the reset sequence twice (divider ratio 1) |
| pll_lock | input | 1 | PLL lock from the transceiver, asynchronous |
| tx_done | input | 1 | Transmit reset finished, asynchronous |
| rx_done | input | 1 | Receive reset finished, asynchronous |
| pll_rst | output | 1 | PLL reset to the transceiver, active high |
| tx_rst | output | 1 | Transmit reset, active high |
| rx_rst | output | 1 | Receive reset, active high |
| link_ready | output | 1 | Transceiver clock usable |

## Verification
A wrong state or a wrong timer load in this block shows up directly in when the reset pins change relative to the inputs. The sequencer only waits on counters and on synchronized inputs, so every such fault shifts an output edge by a predictable number of cycles. A miscounted blind wait moves the first `pll_rst` edge within the first hundred cycles. A lost second-pass flag changes the number of PLL pulses seen before `link_ready`. A watchdog fault appears one timeout after the missing lock or done. A stuck lock path leaves `link_ready` high a few cycles after lock is removed, when it should already be low.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [2:0] {
    ST_BLIND,
    ST_PLL_RST,
    ST_LOCK_WAIT,
    ST_TXRX_HOLD,
    ST_DONE_WAIT,
    ST_READY
  } xrs_state_e;

  // Cycles of a clock at freq_hz that cover at least ns nanoseconds.
  function automatic int blind_cycles(input longint freq_hz, input longint ns);
    longint prod;
    prod = freq_hz * ns + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= '0;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xrs_cycle_timer.sv
module xrs_cycle_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= RST_VAL;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/xrs_reset_seq.sv
module xrs_reset_seq
  import xrs_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int BLIND_NS    = 2500,
  parameter int PLL_PULSE   = 8,
  parameter int TXRX_HOLD   = 8,
  parameter int LOCK_TO     = 4096,
  parameter int DONE_TO     = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div1_mode,
  input  logic pll_lock,
  input  logic tx_done,
  input  logic rx_done,
  output logic pll_rst,
  output logic tx_rst,
  output logic rx_rst,
  output logic link_ready
);
  localparam int BLIND_CYC = blind_cycles(longint'(CLK_FREQ_HZ), longint'(BLIND_NS));
  localparam int MAXC = max_of(max_of(BLIND_CYC, PLL_PULSE),
                               max_of(max_of(TXRX_HOLD, LOCK_TO), DONE_TO));
  localparam int TW = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LD_BLIND = TW'(BLIND_CYC - 1);
  localparam logic [TW-1:0] LD_PULSE = TW'(PLL_PULSE - 1);
  localparam logic [TW-1:0] LD_HOLD  = TW'(TXRX_HOLD - 1);
  localparam logic [TW-1:0] LD_LOCK  = TW'(LOCK_TO - 1);
  localparam logic [TW-1:0] LD_DONE  = TW'(DONE_TO - 1);

  xrs_state_e    state, state_nxt;
  logic          second, set_second, clr_second;
  logic          ld;
  logic [TW-1:0] ld_val;
  logic          t_zero;
  logic [2:0]    sync_q;
  logic          lock_s, done_s;

  xrs_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pll_lock, tx_done, rx_done}),
    .q     (sync_q)
  );
  assign lock_s = sync_q[2];
  assign done_s = sync_q[1] & sync_q[0];

  xrs_cycle_timer #(.W(TW), .RST_VAL(LD_BLIND)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .zero     (t_zero)
  );

  always_comb begin
    state_nxt  = state;
    ld         = 1'b0;
    ld_val     = LD_PULSE;
    set_second = 1'b0;
    clr_second = 1'b0;
    unique case (state)
      ST_BLIND: if (t_zero) begin
        state_nxt = ST_PLL_RST;
        ld        = 1'b1;
      end
      ST_PLL_RST: if (t_zero) begin
        state_nxt = ST_LOCK_WAIT;
        ld        = 1'b1;
        ld_val    = LD_LOCK;
      end
      ST_LOCK_WAIT: begin
        if (lock_s) begin
          state_nxt = ST_TXRX_HOLD;
          ld        = 1'b1;
          ld_val    = LD_HOLD;
        end else if (t_zero) begin
          state_nxt  = ST_PLL_RST;
          ld         = 1'b1;
          clr_second = 1'b1;
        end
      end
      ST_TXRX_HOLD: if (t_zero) begin
        state_nxt = ST_DONE_WAIT;
        ld        = 1'b1;
        ld_val    = LD_DONE;
      end
      ST_DONE_WAIT: begin
        if (done_s) begin
          if (div1_mode && !second) begin
            state_nxt  = ST_PLL_RST;
            ld         = 1'b1;
            set_second = 1'b1;
          end else begin
            state_nxt = ST_READY;
          end
        end else if (t_zero) begin
          state_nxt  = ST_PLL_RST;
          ld         = 1'b1;
          clr_second = 1'b1;
        end
      end
      ST_READY: if (!lock_s) begin
        state_nxt  = ST_PLL_RST;
        ld         = 1'b1;
        clr_second = 1'b1;
      end
      default: state_nxt = ST_BLIND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_BLIND;
      second <= 1'b0;
    end else begin
      state <= state_nxt;
      if (set_second)      second <= 1'b1;
      else if (clr_second) second <= 1'b0;
    end
  end

  assign pll_rst    = (state == ST_PLL_RST);
  assign tx_rst     = (state == ST_PLL_RST) || (state == ST_LOCK_WAIT) || (state == ST_TXRX_HOLD);
  assign rx_rst     = tx_rst;
  assign link_ready = (state == ST_READY);
endmodule

// File: rtl/xrs_reset_seq_chk.sv
module xrs_reset_seq_chk
  import xrs_pkg::*;
#(
  parameter int BLIND_CYC = 1,
  parameter int LOCK_TO   = 1,
  parameter int DONE_TO   = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_rst,
  input logic       tx_rst,
  input logic       rx_rst,
  input logic       link_ready,
  input logic       tx_done,
  input logic       rx_done,
  input logic       lock_s,
  input xrs_state_e st
);
  int unsigned since_rst, lw_cnt, dw_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      lw_cnt    <= 0;
      dw_cnt    <= 0;
    end else begin
      if (since_rst < BLIND_CYC) since_rst <= since_rst + 1;
      lw_cnt <= (st == ST_LOCK_WAIT) ? lw_cnt + 1 : 0;
      dw_cnt <= (st == ST_DONE_WAIT) ? dw_cnt + 1 : 0;
    end
  end

  a_r2_blind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < BLIND_CYC) |-> (!pll_rst && !tx_rst && !rx_rst));
  a_r3_txrx_cover_pll: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> (tx_rst && rx_rst));
  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> ($past(tx_done) && $past(rx_done)));
  a_r5_ready_resets_low: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> (!pll_rst && !tx_rst && !rx_rst));
  a_r7_lock_loss_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && !lock_s) |=> !link_ready);
  a_r8_lock_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
    lw_cnt <= LOCK_TO);
  a_r9_done_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
    dw_cnt <= DONE_TO);
endmodule

bind xrs_reset_seq xrs_reset_seq_chk #(
  .BLIND_CYC (BLIND_CYC),
  .LOCK_TO   (LOCK_TO),
  .DONE_TO   (DONE_TO)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_rst    (pll_rst),
  .tx_rst     (tx_rst),
  .rx_rst     (rx_rst),
  .link_ready (link_ready),
  .tx_done    (tx_done),
  .rx_done    (rx_done),
  .lock_s     (lock_s),
  .st         (state)
);

// File: tb/xrs_reset_seq_tb_top.sv
module xrs_reset_seq_tb_top;
  localparam int CLK_P  = 10;
  localparam int FREQ   = 33_000_000;
  localparam int BNS    = 2500;
  localparam int EXP_BL = 83;
  localparam int PP     = 5;
  localparam int HOLD   = 4;
  localparam int LTO    = 40;
  localparam int DTO    = 30;
  localparam int SS     = 2;
  localparam int LK_DLY = 10;
  localparam int DN_DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, div1_mode = 1'b0;
  logic pll_lock = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic pll_rst, tx_rst, rx_rst, link_ready;
  bit   lock_en = 1'b1, tx_en = 1'b1, rx_en = 1'b1;
  int   lk_cnt = 0, tx_cnt = 0, rx_cnt = 0;
  int   cyc = 0, n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  xrs_reset_seq #(
    .CLK_FREQ_HZ(FREQ), .BLIND_NS(BNS), .PLL_PULSE(PP), .TXRX_HOLD(HOLD),
    .LOCK_TO(LTO), .DONE_TO(DTO), .SYNC_STAGES(SS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .div1_mode(div1_mode), .pll_lock(pll_lock),
    .tx_done(tx_done), .rx_done(rx_done), .pll_rst(pll_rst), .tx_rst(tx_rst),
    .rx_rst(rx_rst), .link_ready(link_ready)
  );

  // Transceiver model: drives its outputs on the falling edge.
  always @(negedge clk) begin
    if (!rst_n || pll_rst || !lock_en) begin lk_cnt <= 0; pll_lock <= 1'b0; end
    else if (lk_cnt < LK_DLY) lk_cnt <= lk_cnt + 1;
    else pll_lock <= 1'b1;
    if (!rst_n || tx_rst || !tx_en) begin tx_cnt <= 0; tx_done <= 1'b0; end
    else if (tx_cnt < DN_DLY) tx_cnt <= tx_cnt + 1;
    else tx_done <= 1'b1;
    if (!rst_n || rx_rst || !rx_en) begin rx_cnt <= 0; rx_done <= 1'b0; end
    else if (rx_cnt < DN_DLY) rx_cnt <= rx_cnt + 1;
    else rx_done <= 1'b1;
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    cyc++;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit d1, input bit le, input bit te, input bit re);
    rst_n = 1'b0; div1_mode = d1; lock_en = le; tx_en = te; rx_en = re;
    repeat (4) tick();
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic t_startup();
    int first_pll = -1, early = 0, width = 0, uncovered = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 outputs in reset", {pll_rst, tx_rst, rx_rst, link_ready}, 0);
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 500 && first_pll < 0; i++) begin
      tick();
      if (pll_rst) first_pll = cyc;
      else if (tx_rst || rx_rst) early++;
    end
    chk("R2 blind wait length", first_pll, EXP_BL);
    chk("R2 no reset during blind", early, 0);
    while (pll_rst && width < 100) begin
      width++;
      if (!(tx_rst && rx_rst)) uncovered++;
      tick();
    end
    chk("R3 pll pulse width", width, PP);
    chk("R3 tx/rx held with pll", uncovered, 0);
  endtask

  task automatic run_to_ready(input string tag, input int exp_pulses, input bit timing);
    int pulses = 0, t_lock = -1, t_txf = -1, t_dn = -1, t_rdy = -1, bad = 0;
    bit pp = pll_rst, pl = pll_lock, pt = tx_rst, pd = tx_done && rx_done;
    for (int i = 0; i < 3000 && t_rdy < 0; i++) begin
      tick();
      if (pll_rst && !pp) pulses++;
      if (pll_lock && !pl) t_lock = cyc;
      if (!tx_rst && pt) t_txf = cyc;
      if ((tx_done && rx_done) && !pd) t_dn = cyc;
      if (link_ready) begin
        t_rdy = cyc;
        if (!(tx_done && rx_done)) bad++;
      end
      pp = pll_rst; pl = pll_lock; pt = tx_rst; pd = tx_done && rx_done;
    end
    chk({tag, " R6 pll pulses before ready"}, pulses, exp_pulses);
    chk({tag, " R5 ready reached with done"}, (t_rdy > 0 && bad == 0) ? 1 : 0, 1);
    if (timing) begin
      chk({tag, " R4 lock to tx/rx release"}, t_txf - t_lock, SS + HOLD);
      chk({tag, " R5 done to ready"}, t_rdy - t_dn, SS);
    end
  endtask

  task automatic t_single();
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    run_to_ready("single", 1, 1'b1);
  endtask

  task automatic t_double();
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    run_to_ready("double", 2, 1'b1);
  endtask

  task automatic t_lock_loss();
    int t_lf = -1, t_rf = -1, t_pr = -1;
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    run_to_ready("pre-loss", 1, 1'b0);
    lock_en = 1'b0;
    for (int i = 0; i < 50 && t_rf < 0; i++) begin
      tick();
      if (!pll_lock && t_lf < 0) t_lf = cyc;
      if (!link_ready && t_rf < 0) t_rf = cyc;
      if (pll_rst && t_pr < 0) t_pr = cyc;
    end
    chk("R7 ready falls after lock loss", t_rf - t_lf, SS);
    chk("R7 pll reset after lock loss", t_pr - t_lf, SS);
    lock_en = 1'b1;
    run_to_ready("R7 recovery", 0, 1'b0);
  endtask

  task automatic t_lock_wd();
    int t_f = -1, t_r = -1, rdy = 0;
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 400 && t_r < 0; i++) begin
      tick();
      if (link_ready) rdy++;
      if (t_f < 0 && tx_rst && !pll_rst) t_f = cyc;
      else if (t_f >= 0 && pll_rst) t_r = cyc;
    end
    chk("R8 lock watchdog period", t_r - t_f, LTO);
    chk("R8 no ready without lock", rdy, 0);
  endtask

  task automatic t_done_wd();
    int t_f = -1, t_r = -1, rdy = 0;
    bit pt;
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    pt = 1'b0;
    for (int i = 0; i < 400 && t_r < 0; i++) begin
      tick();
      if (link_ready) rdy++;
      if (t_f < 0 && pt && !tx_rst) t_f = cyc;
      else if (t_f >= 0 && pll_rst) t_r = cyc;
      pt = tx_rst;
    end
    chk("R9 done watchdog period", t_r - t_f, DTO);
    chk("R5 no ready with rx_done low", rdy, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_startup();
    t_single();
    t_double();
    t_lock_loss();
    t_lock_wd();
    t_done_wd();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule